// File: doc/BRIEF.md
# Chip-Select Window Decoder

This block steers a physical memory address to one of four chip selects. Each chip select has a 32-bit bounds word. The upper half gives the first 16 MiB block the chip select owns. The lower half gives the last block it owns, and that last block is included. The block index of an address is its bits from 24 upward. A chip select whose two halves are equal holds no memory. It never claims an address. When windows overlap, the lowest-numbered chip select wins. When no populated window covers the address, the block raises a miss flag.

Lookups travel as a stream. A request carries `req_addr` and is accepted when `req_valid` and `req_ready` are both high. The bounds words are sampled in the same cycle. With the default output register, the result appears on the response side the cycle after acceptance. It stays unchanged while `rsp_valid` is high and `rsp_ready` is low. A new request is accepted only when the response slot is empty or is being drained in the same cycle. Setting `OUT_REG` to 0 makes the path purely combinational: the response follows the request directly.

A separate, plain control path reads a configuration word and reports the memory generation and whether the DIMMs are registered. This path is combinational and is not part of the stream.

Top module: `csb_addr_decode`

## Requirements
- R1: An accepted address whose block index (address bits 35..24) lies between the start field (bounds bits 31..16) and the end field (bounds bits 15..0) of a populated chip select selects that chip select. This includes every byte of the end block.
- R2: An address whose block index is below a chip select's start field, or above its end field, is not selected by that chip select.
- R3: A chip select whose start field equals its end field is never selected.
- R4: When more than one chip select matches, `rsp_cs` has only the bit of the lowest-numbered matching chip select set. Bit i of `rsp_cs` stands for chip select i.
- R5: `rsp_miss` is high exactly when no chip select matches, and `rsp_cs` is then all zero.
- R6: `mem_type` decodes configuration bits 26..24 as follows: 2 gives 1 (DDR), 3 gives 2 (DDR2), 7 gives 3 (DDR3), 5 gives 4 (DDR4), and any other value gives 0 (unknown). The output follows the configuration word in the same cycle.
- R7: `mem_registered` equals configuration bit 30 when the type is known, and is 0 when the type is unknown.
- R8: With the output register present, an accepted request produces `rsp_valid` with its result on the next cycle. A pending response holds its value unchanged while `rsp_ready` is low.
- R9: `req_ready` is high when no response is pending or when the pending one is being taken. Every accepted request yields exactly one response, and responses come out in order.
- R10: While reset is asserted, `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request can be taken |
| req_addr | input | 36 | Physical address to decode |
| cs_bounds | input | 128 | Four bounds words; chip select i uses bits 32i+31..32i |
| rsp_valid | output | 1 | Decode result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_cs | output | 4 | One-hot selected chip select |
| rsp_miss | output | 1 | No populated window covers the address |
| cfg_word | input | 32 | Memory configuration word |
| mem_type | output | 3 | Decoded memory generation |
| mem_registered | output | 1 | Registered-DIMM variant in use |

## Verification
The decode result is due one clock after the posedge at which the request is accepted. The type outputs are due in the same cycle as the configuration word. The bench drives inputs just after each rising edge. It advances its reference model at the same rising edge the design uses to accept a request, and it compares every output at the following falling edge. The expected values therefore line up with the cycle in which each result is registered. Back-pressure phases hold `rsp_ready` low at random, which exercises the hold rule and the acceptance rule against the model's own occupancy bit.

// File: rtl/csb_pkg.sv
package csb_pkg;
  localparam int CFG_TYPE_LSB = 24;
  localparam int CFG_TYPE_W   = 3;
  localparam int CFG_RDIMM    = 30;

  typedef enum logic [2:0] {
    MK_UNKNOWN = 3'd0,
    MK_DDR1    = 3'd1,
    MK_DDR2    = 3'd2,
    MK_DDR3    = 3'd3,
    MK_DDR4    = 3'd4
  } mem_kind_e;
endpackage

// File: rtl/csb_window_match.sv
module csb_window_match #(
  parameter int FIELD_W = 16
) (
  input  logic [FIELD_W-1:0]   blk_idx,
  input  logic [2*FIELD_W-1:0] bounds,
  output logic                 hit
);
  logic [FIELD_W-1:0] lo_blk;
  logic [FIELD_W-1:0] hi_blk;
  logic               populated;

  assign lo_blk    = bounds[2*FIELD_W-1:FIELD_W];
  assign hi_blk    = bounds[FIELD_W-1:0];
  assign populated = (lo_blk != hi_blk);
  assign hit       = populated && (blk_idx >= lo_blk) && (blk_idx <= hi_blk);
endmodule

// File: rtl/csb_prio_pick.sv
module csb_prio_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         none
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_pick
    assign grant[i]  = req[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req[i];
  end

  assign none = ~seen[N];
endmodule

// File: rtl/csb_memtype_decode.sv
module csb_memtype_decode
  import csb_pkg::*;
(
  input  logic [CFG_TYPE_W-1:0] type_field,
  input  logic                  rdimm_en,
  output logic [2:0]            kind,
  output logic                  registered
);
  mem_kind_e k;

  always_comb begin
    case (type_field)
      3'd2:    k = MK_DDR1;
      3'd3:    k = MK_DDR2;
      3'd7:    k = MK_DDR3;
      3'd5:    k = MK_DDR4;
      default: k = MK_UNKNOWN;
    endcase
  end

  assign kind       = k;
  assign registered = rdimm_en && (k != MK_UNKNOWN);
endmodule

// File: rtl/csb_addr_decode.sv
module csb_addr_decode
  import csb_pkg::*;
#(
  parameter int ADDR_W    = 36,
  parameter int BLK_SHIFT = 24,
  parameter int NUM_CS    = 4,
  parameter int FIELD_W   = 16,
  parameter bit OUT_REG   = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [NUM_CS*2*FIELD_W-1:0] cs_bounds,
  output logic                      rsp_valid,
  input  logic                      rsp_ready,
  output logic [NUM_CS-1:0]         rsp_cs,
  output logic                      rsp_miss,
  input  logic [31:0]               cfg_word,
  output logic [2:0]                mem_type,
  output logic                      mem_registered
);
  localparam int BW     = 2 * FIELD_W;
  localparam int IDX_W  = ADDR_W - BLK_SHIFT;
  localparam logic [31:0] CFG_USED =
    ((32'd1 << CFG_TYPE_W) - 32'd1) << CFG_TYPE_LSB | (32'd1 << CFG_RDIMM);

  logic [FIELD_W-1:0] blk_idx;
  logic [NUM_CS-1:0]  win_hit;
  logic [NUM_CS-1:0]  pick;
  logic               pick_none;

  assign blk_idx = FIELD_W'(req_addr[ADDR_W-1:BLK_SHIFT]);

  for (genvar c = 0; c < NUM_CS; c++) begin : g_win
    csb_window_match #(.FIELD_W(FIELD_W)) u_win (
      .blk_idx (blk_idx),
      .bounds  (cs_bounds[c*BW +: BW]),
      .hit     (win_hit[c])
    );
  end

  csb_prio_pick #(.N(NUM_CS)) u_pick (
    .req   (win_hit),
    .grant (pick),
    .none  (pick_none)
  );

  if (OUT_REG) begin : g_reg
    logic              v_q;
    logic [NUM_CS-1:0] cs_q;
    logic              miss_q;
    logic              take;

    assign req_ready = !v_q || rsp_ready;
    assign take      = req_valid && req_ready;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q    <= 1'b0;
        cs_q   <= '0;
        miss_q <= 1'b0;
      end else begin
        if (req_ready) v_q <= req_valid;
        if (take) begin
          cs_q   <= pick;
          miss_q <= pick_none;
        end
      end
    end

    assign rsp_valid = v_q;
    assign rsp_cs    = cs_q;
    assign rsp_miss  = miss_q;
  end else begin : g_comb
    logic unused_clk_rst;
    assign unused_clk_rst = clk ^ rst_n;
    assign req_ready = rsp_ready;
    assign rsp_valid = req_valid;
    assign rsp_cs    = pick;
    assign rsp_miss  = pick_none;
  end

  csb_memtype_decode u_type (
    .type_field (cfg_word[CFG_TYPE_LSB +: CFG_TYPE_W]),
    .rdimm_en   (cfg_word[CFG_RDIMM]),
    .kind       (mem_type),
    .registered (mem_registered)
  );

  logic unused_bits;
  assign unused_bits = ^(cfg_word & ~CFG_USED) ^ ^req_addr[BLK_SHIFT-1:0] ^ (IDX_W > 0);
endmodule

// File: rtl/csb_addr_decode_chk.sv
module csb_addr_decode_chk #(
  parameter int NUM_CS  = 4,
  parameter bit OUT_REG = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [NUM_CS-1:0] rsp_cs,
  input logic              rsp_miss,
  input logic [2:0]        mem_type,
  input logic              mem_registered
);
  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot0(rsp_cs)); // R4

  AST_MISS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_miss) |-> (rsp_cs == '0)); // R5

  AST_HIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_miss) |-> ($countones(rsp_cs) == 1)); // R5

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (OUT_REG && rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_cs) && $stable(rsp_miss))); // R8

  AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (OUT_REG && req_valid && req_ready) |=> rsp_valid); // R8

  AST_EMPTY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (OUT_REG && !rsp_valid) |-> req_ready); // R9

  AST_REG_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_registered |-> (mem_type != 3'd0)); // R7

  AST_TYPE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_type <= 3'd4); // R6
endmodule

bind csb_addr_decode csb_addr_decode_chk #(.NUM_CS(NUM_CS), .OUT_REG(OUT_REG)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .rsp_valid      (rsp_valid),
  .rsp_ready      (rsp_ready),
  .rsp_cs         (rsp_cs),
  .rsp_miss       (rsp_miss),
  .mem_type       (mem_type),
  .mem_registered (mem_registered)
);

// File: tb/csb_addr_decode_test.sv
`timescale 1ns/1ps
module csb_addr_decode_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [35:0] req_addr = '0;
  logic [31:0] bnd [4];
  logic [127:0] cs_bounds;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [3:0]  rsp_cs;
  logic        rsp_miss;
  logic [31:0] cfg_word = '0;
  logic [2:0]  mem_type;
  logic        mem_registered;

  always #2.5 clk = ~clk;

  assign cs_bounds = {bnd[3], bnd[2], bnd[1], bnd[0]};

  csb_addr_decode uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .cs_bounds(cs_bounds), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_cs(rsp_cs), .rsp_miss(rsp_miss),
    .cfg_word(cfg_word), .mem_type(mem_type), .mem_registered(mem_registered)
  );

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  bit    bp_mode = 0;
  string cur_req = "R1";

  bit        m_valid = 0;
  logic [3:0] m_cs   = '0;
  bit        m_miss  = 0;

  task automatic chk(bit ok, string tag, string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s got %0h expected %0h at %0t", tag, what, got, exp, $time);
    end
  endtask

  function automatic logic [3:0] ref_cs(logic [35:0] a);
    int blk = int'(a >> 24);
    for (int i = 0; i < 4; i++) begin
      int s = int'(bnd[i][31:16]);
      int e = int'(bnd[i][15:0]);
      if (s != e && blk >= s && blk <= e) return 4'(1 << i);
    end
    return 4'd0;
  endfunction

  function automatic int ref_type(logic [31:0] w);
    int f = int'(w[26:24]);
    if (f == 2) return 1;
    if (f == 3) return 2;
    if (f == 7) return 3;
    if (f == 5) return 4;
    return 0;
  endfunction

  // reference model: advances at the same edge the design registers on
  always @(posedge clk) begin
    if (!rst_n) m_valid = 0;
    else if (!m_valid || rsp_ready) begin
      if (req_valid) begin
        m_valid = 1;
        m_cs    = ref_cs(req_addr);
        m_miss  = (m_cs == 4'd0);
      end else m_valid = 0;
    end
  end

  always @(posedge clk) if (bp_mode) #1 rsp_ready = 1'($urandom % 2);

  // comparison away from the active edge
  always @(negedge clk) begin
    int et;
    if (!rst_n) begin
      chk(rsp_valid == 1'b0, "R10", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
    end else begin
      chk(rsp_valid == m_valid, "R8", "rsp_valid", 64'(rsp_valid), 64'(m_valid));
      chk(req_ready == (!m_valid || rsp_ready), "R9", "req_ready",
          64'(req_ready), 64'(!m_valid || rsp_ready));
      if (m_valid) begin
        chk(rsp_cs == m_cs, cur_req, "rsp_cs", 64'(rsp_cs), 64'(m_cs));
        chk(rsp_miss == m_miss, cur_req, "rsp_miss", 64'(rsp_miss), 64'(m_miss));
      end
    end
    et = ref_type(cfg_word);
    chk(int'(mem_type) == et, "R6", "mem_type", 64'(mem_type), 64'(et));
    chk(mem_registered == (cfg_word[30] && et != 0), "R7", "mem_registered",
        64'(mem_registered), 64'(cfg_word[30] && et != 0));
  end

  // call just after a rising edge; returns just after the accepting edge
  task automatic send(logic [35:0] a);
    bit acc = 0;
    #1 req_valid = 1'b1; req_addr = a;
    while (!acc) begin
      @(negedge clk); acc = req_ready;
      @(posedge clk);
    end
  endtask

  task automatic idle(int n);
    #1 req_valid = 1'b0;
    repeat (n) @(posedge clk);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) bnd[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk);

    // cs0 owns blocks 1..3, cs1 unpopulated, cs2/cs3 overlap on 0x20..0x2F
    bnd[0] = {16'h0001, 16'h0003};
    bnd[1] = {16'h0010, 16'h0010};
    bnd[2] = {16'h0020, 16'h002F};
    bnd[3] = {16'h0020, 16'h0FFF};

    cur_req = "R1";
    send(36'h0_0100_0000); send(36'h0_03FF_FFFF); send(36'h0_0234_5678);
    send(36'hF_FFFF_FFFF);
    cur_req = "R2";
    send(36'h0_00FF_FFFF); send(36'h0_0400_0000); send(36'h0_1FFF_FFFF);
    cur_req = "R3";
    send(36'h0_1000_0000); send(36'h0_10FF_FFFF);
    cur_req = "R4";
    send(36'h0_2000_0000); send(36'h0_2FFF_FFFF); send(36'h0_3000_0000);
    cur_req = "R5";
    send(36'h0_0000_0000); send(36'h0_0FFF_FFFF);
    idle(2);

    // start above end acts as an empty window
    #1 bnd[0] = {16'h0005, 16'h0002};
    cur_req = "R2";
    send(36'h0_0300_0000); send(36'h0_0500_0000);
    idle(2);

    cur_req = "R6";
    for (int t = 0; t < 8; t++) begin
      for (int r = 0; r < 2; r++) begin
        #1 cfg_word = (32'(t) << 24) | (32'(r) << 30) | 32'h0000_1234;
        @(posedge clk);
      end
    end

    // back-pressure and random stream
    cur_req = "R9";
    bp_mode = 1;
    for (int n = 0; n < 400; n++) begin
      logic [35:0] a = {4'h0, 8'($urandom % 64), 24'($urandom)};
      if (n % 50 == 0) begin
        #1 bnd[n % 4] = {16'($urandom % 48), 16'($urandom % 48)};
        @(posedge clk);
      end
      if ($urandom % 4 == 0) idle(1);
      send(a);
    end
    idle(4);
    bp_mode = 0;
    #1 rsp_ready = 1'b1;
    @(posedge clk); @(posedge clk);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R9 watchdog expired got 0 expected 1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule